// File: doc/BRIEF.md
# Keyed Fractional Clock Divider

This block turns one of several source tick strobes into a divided output level. All sources are clock-enable strobes in the single system clock domain. A source tick is one cycle in which the selected strobe is high. Software programs the block through two 32-bit registers on a simple write/read port. The control word selects the source, the shaping mode, output inversion, kill and enable. The divisor word holds a 12.12 fixed-point ratio. A register write takes effect only when its top byte carries the unlock key `0x5A`.

Each output period lasts N source ticks, where N is the integer part of the divisor. The output is high for the first ceil(N/2) ticks of the period and low for the rest. In shaping mode 0 the fraction is ignored. In any non-zero mode, a first-order accumulator stretches some periods to N+1 ticks, so the average ratio equals the full fixed-point value.

When the generator starts, it captures the source, divisor and mode. Later writes then cannot disturb a running output. The safe way to reprogram the block is:
1. Assert kill.
2. Wait for busy to drop.
3. Write the divisor.
4. Write the control word with enable low.
5. Write the control word with enable high.

Top module: `frac_clk_div`

## Requirements
- R1: A write changes a register only when `wdata_i[31:24]` equals `0x5A`. A write with any other top byte leaves both registers and the output unchanged.
- R2: Reading address 0 returns the control word: shaping mode in bits 10:9, flip in bit 8, busy in bit 7, kill in bit 5, enable in bit 4, source in bits 3:0, and zeros elsewhere. Reading address 1 returns the integer part in bits 23:12 and the fraction in bits 11:0, with bits 31:24 zero.
- R3: Consider an idle generator with kill low. Once the stored enable bit is high, busy rises on the next clock edge and the output enters the high phase of its first period in that same cycle.
- R4: With shaping mode 0, every period is exactly N source ticks long, with ceil(N/2) high ticks followed by floor(N/2) low ticks. The fraction has no effect. An integer part of 0 behaves as 1, and N=1 keeps the output high while running.
- R5: Source values 0 to 7 select bits of `src_tick_i`. Source values 8 to 15 supply no ticks, so the output makes no edges after its start.
- R6: A stored kill bit clears busy on the next clock edge, which returns the output to its idle level at once. While kill stays set, the generator does not restart.
- R7: When enable is cleared during a run, busy stays high until the current high phase has completed. Busy drops at the first edge at which the output is or becomes low, and the output returns to its idle level.
- R8: With a non-zero shaping mode, the fraction is added to a 12-bit accumulator (cleared at start) at the end of each period. A carry out makes the next period one tick longer, with high length ceil(P/2) for period length P.
- R9: The flip bit inverts the output. While idle it takes effect on the next edge. While running it is picked up only at a period boundary.
- R10: Divisor, shaping mode and source writes made while busy is high are stored and read back, but do not change the running output until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 control, 1 divisor |
| wdata_i | input | 32 | Write data, key in bits 31:24 |
| rdata_o | output | 32 | Read data for the register at `addr_i` |
| src_tick_i | input | N_SRC | Source tick strobes |
| clk_o | output | 1 | Divided output level |
| busy_o | output | 1 | Generator running |

## Verification
The divider is driven with three tick patterns:
- Silence shows that ground sources produce no edges.
- A tick on every cycle exposes exact period lengths and the placement of stretched periods in shaping mode.
- A pseudo-random sparse pattern shows that counting follows ticks and not clock cycles.

Integer parts 0, 1, 2, 3 and 5 separate the even, odd and degenerate high-length cases. A fraction of 0x800 under mode 0 shows that the fraction is ignored. A fraction of 0x555 under mode 1 shows irregular carry spacing.

Enable is dropped during high and low phases, kill is applied mid-period, and flip and divisor are rewritten mid-run. Together these separate immediate effects from effects deferred to a boundary or to the next start.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam logic [7:0] KEY    = 8'h5A;
  localparam int         SRC_W  = 4;
  localparam int         MODE_W = 2;
  localparam int         DIV_IW = 12;
  localparam int         DIV_FW = 12;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic              flip;
    logic              kill;
    logic              enab;
    logic [SRC_W-1:0]  src;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/fcd_regs.sv
module fcd_regs
  import fcd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              busy_i,
  output logic [31:0]       rdata_o,
  output ctrl_t             ctrl_o,
  output logic [DIV_IW-1:0] divi_o,
  output logic [DIV_FW-1:0] divf_o
);
  logic unlocked;
  assign unlocked = wr_en_i && (wdata_i[31:24] == KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      divi_o <= '0;
      divf_o <= '0;
    end else if (unlocked) begin
      if (!addr_i) begin
        ctrl_o.mode <= wdata_i[10:9];
        ctrl_o.flip <= wdata_i[8];
        ctrl_o.kill <= wdata_i[5];
        ctrl_o.enab <= wdata_i[4];
        ctrl_o.src  <= wdata_i[3:0];
      end else begin
        divi_o <= wdata_i[DIV_FW+DIV_IW-1:DIV_FW];
        divf_o <= wdata_i[DIV_FW-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (!addr_i) begin
      rdata_o[10:9] = ctrl_o.mode;
      rdata_o[8]    = ctrl_o.flip;
      rdata_o[7]    = busy_i;
      rdata_o[5]    = ctrl_o.kill;
      rdata_o[4]    = ctrl_o.enab;
      rdata_o[3:0]  = ctrl_o.src;
    end else begin
      rdata_o[DIV_FW+DIV_IW-1:DIV_FW] = divi_o;
      rdata_o[DIV_FW-1:0]             = divf_o;
    end
  end
endmodule

// File: rtl/fcd_core.sv
module fcd_core
  import fcd_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctrl_t             ctrl_i,
  input  logic [DIV_IW-1:0] divi_i,
  input  logic [DIV_FW-1:0] divf_i,
  input  logic [N_SRC-1:0]  src_tick_i,
  output logic [SRC_W-1:0]  src_w_o,
  output logic              busy_o,
  output logic              clk_o
);
  localparam int CW = DIV_IW + 1;

  logic              run_q, ext_q, inv_q, shape_q;
  logic [CW-1:0]     cnt_q;
  logic [DIV_FW-1:0] acc_q, frac_q;
  logic [DIV_IW-1:0] n_q;
  logic [SRC_W-1:0]  src_q;

  // tick mux; selects at or above N_SRC match no lane and read as ground
  logic [N_SRC-1:0] hit;
  for (genvar g = 0; g < N_SRC; g++) begin : g_lane
    assign hit[g] = src_tick_i[g] && (src_q == SRC_W'(g));
  end
  logic tick;
  assign tick = |hit;

  logic [CW-1:0]     n_eff, per_len, hi_len;
  logic              in_low, at_last, at_hi_last, stop, wrap;
  logic [DIV_FW:0]   sum;

  assign n_eff      = (n_q == '0) ? CW'(1) : {1'b0, n_q};
  assign per_len    = n_eff + CW'(ext_q);
  assign hi_len     = (per_len + CW'(1)) >> 1;
  assign in_low     = cnt_q >= hi_len;
  assign at_last    = cnt_q == per_len - CW'(1);
  assign at_hi_last = cnt_q == hi_len - CW'(1);
  assign stop       = run_q && !ctrl_i.enab && (in_low || (tick && at_hi_last));
  assign wrap       = run_q && !ctrl_i.kill && !stop && tick && at_last;
  assign sum        = {1'b0, acc_q} + {1'b0, frac_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      acc_q   <= '0;
      ext_q   <= 1'b0;
      n_q     <= '0;
      frac_q  <= '0;
      shape_q <= 1'b0;
      src_q   <= '0;
    end else if (ctrl_i.kill) begin
      run_q <= 1'b0;
    end else if (!run_q) begin
      if (ctrl_i.enab) begin
        run_q   <= 1'b1;
        cnt_q   <= '0;
        acc_q   <= '0;
        ext_q   <= 1'b0;
        n_q     <= divi_i;
        frac_q  <= divf_i;
        shape_q <= |ctrl_i.mode;
        src_q   <= ctrl_i.src;
      end
    end else if (stop) begin
      run_q <= 1'b0;
    end else if (tick) begin
      if (at_last) begin
        cnt_q <= '0;
        if (shape_q) begin
          acc_q <= sum[DIV_FW-1:0];
          ext_q <= sum[DIV_FW];
        end else begin
          ext_q <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // inversion only picked up when idle or on a period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                inv_q <= 1'b0;
    else if (!run_q || wrap)    inv_q <= ctrl_i.flip;
  end

  assign busy_o  = run_q;
  assign clk_o   = (run_q && !in_low) ^ inv_q;
  assign src_w_o = src_q;
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import fcd_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic [N_SRC-1:0] src_tick_i,
  output logic             clk_o,
  output logic             busy_o
);
  ctrl_t             ctrl;
  logic [DIV_IW-1:0] divi;
  logic [DIV_FW-1:0] divf;
  logic [SRC_W-1:0]  src_w;

  fcd_regs i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .busy_i  (busy_o),
    .rdata_o (rdata_o),
    .ctrl_o  (ctrl),
    .divi_o  (divi),
    .divf_o  (divf)
  );

  fcd_core #(.N_SRC(N_SRC)) i_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_i     (ctrl),
    .divi_i     (divi),
    .divf_i     (divf),
    .src_tick_i (src_tick_i),
    .src_w_o    (src_w),
    .busy_o     (busy_o),
    .clk_o      (clk_o)
  );
endmodule

// File: rtl/fcd_chk.sv
module fcd_chk
  import fcd_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic                              wr_en_i,
  input logic [31:0]                       wdata_i,
  input logic [CTRL_W+DIV_IW+DIV_FW-1:0]   cfg_i,
  input logic                              kill_i,
  input logic                              enab_i,
  input logic [SRC_W-1:0]                  src_w_i,
  input logic                              busy_i,
  input logic                              clk_out_i
);
  a_r1_key_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wdata_i[31:24] != KEY) |=> $stable(cfg_i));

  a_r3_busy_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(enab_i && !kill_i));

  a_r6_kill_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |=> !busy_i);

  a_r5_ground_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i) && 32'(src_w_i) >= N_SRC) |-> $stable(clk_out_i));

  a_r7_stop_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> $past(kill_i || !enab_i));
endmodule

bind frac_clk_div fcd_chk #(.N_SRC(N_SRC)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wdata_i   (wdata_i),
  .cfg_i     ({ctrl, divi, divf}),
  .kill_i    (ctrl.kill),
  .enab_i    (ctrl.enab),
  .src_w_i   (src_w),
  .busy_i    (busy_o),
  .clk_out_i (clk_o)
);

// File: tb/test_frac_clk_div.sv
`timescale 1ns/1ps
module test_frac_clk_div;
  localparam int N_SRC = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             wr_en_i = 1'b0;
  logic             addr_i = 1'b0;
  logic [31:0]      wdata_i = '0;
  logic [31:0]      rdata_o;
  logic [N_SRC-1:0] src_tick_i = '0;
  logic             clk_o, busy_o;

  frac_clk_div #(.N_SRC(N_SRC)) i_frac_clk_div (.*);

  always #10 clk_i = ~clk_i;

  int checks = 0, fails = 0;
  string cur_req = "R3";
  bit cmp_en = 0;
  int tick_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  int m_mode, m_flip, m_kill, m_enab, m_src, m_divi, m_divf;
  int m_run, m_cnt, m_acc, m_ext, m_inv, m_n, m_frac, m_shape, m_srcw;

  function automatic int m_hi();
    int p;
    p = ((m_n == 0) ? 1 : m_n) + m_ext;
    return (p + 1) / 2;
  endfunction

  function automatic int exp_clk();
    return ((m_run != 0 && m_cnt < m_hi()) ? 1 : 0) ^ m_inv;
  endfunction

  function automatic logic [31:0] exp_ctrl();
    return 32'((m_mode << 9) | (m_flip << 8) | (m_run << 7) | (m_kill << 5) | (m_enab << 4) | m_src);
  endfunction

  always @(negedge clk_i) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (tick_mode)
      0: src_tick_i <= '0;
      1: src_tick_i <= '1;
      default: src_tick_i <= lfsr[7:0] & lfsr[15:8];
    endcase
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_mode = 0; m_flip = 0; m_kill = 0; m_enab = 0; m_src = 0; m_divi = 0; m_divf = 0;
      m_run = 0; m_cnt = 0; m_acc = 0; m_ext = 0; m_inv = 0; m_n = 0; m_frac = 0;
      m_shape = 0; m_srcw = 0;
    end else begin
      int tk, p, hi, stp, wrp, ninv, s;
      tk = 0;
      if (m_srcw < N_SRC) tk = src_tick_i[m_srcw];
      p   = ((m_n == 0) ? 1 : m_n) + m_ext;
      hi  = (p + 1) / 2;
      stp = (m_run != 0 && m_enab == 0 && (m_cnt >= hi || (tk != 0 && m_cnt == hi - 1))) ? 1 : 0;
      wrp = (m_run != 0 && m_kill == 0 && stp == 0 && tk != 0 && m_cnt == p - 1) ? 1 : 0;
      ninv = (m_run == 0 || wrp != 0) ? m_flip : m_inv;
      if (m_kill != 0) m_run = 0;
      else if (m_run == 0) begin
        if (m_enab != 0) begin
          m_run = 1; m_cnt = 0; m_acc = 0; m_ext = 0;
          m_n = m_divi; m_frac = m_divf; m_shape = (m_mode != 0); m_srcw = m_src;
        end
      end else if (stp != 0) m_run = 0;
      else if (tk != 0) begin
        if (m_cnt == p - 1) begin
          m_cnt = 0;
          if (m_shape != 0) begin
            s = m_acc + m_frac;
            m_acc = s % 4096;
            m_ext = s / 4096;
          end else m_ext = 0;
        end else m_cnt = m_cnt + 1;
      end
      m_inv = ninv;
      if (wr_en_i && wdata_i[31:24] == 8'h5A) begin
        if (!addr_i) begin
          m_mode = int'(wdata_i[10:9]); m_flip = int'(wdata_i[8]); m_kill = int'(wdata_i[5]);
          m_enab = int'(wdata_i[4]); m_src = int'(wdata_i[3:0]);
        end else begin
          m_divi = int'(wdata_i[23:12]); m_divf = int'(wdata_i[11:0]);
        end
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (cmp_en) begin
      #2;
      chk(32'(clk_o), 32'(exp_clk()), {cur_req, " clk_o"});
      chk(32'(busy_o), 32'(m_run), {cur_req, " busy_o"});
    end
  end

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk_i);
    #1;
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    #1;
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic a, input logic [31:0] exp, input string req);
    @(negedge clk_i);
    #3;
    addr_i = a;
    #1;
    chk(rdata_o, exp, req);
  endtask

  function automatic logic [31:0] ctl(input int mode, input int flip, input int kill,
                                       input int enab, input int src, input int key = 8'h5A);
    return {8'(key), 13'h0, 2'(mode), 1'(flip), 1'b0, 1'b0, 1'(kill), 1'(enab), 4'(src)};
  endfunction

  function automatic logic [31:0] dv(input int ip, input int fp, input int key = 8'h5A);
    return {8'(key), 12'(ip), 12'(fp)};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic reprogram(input int ip, input int fp, input int mode, input int flip, input int src);
    wr(0, ctl(mode, flip, 1, 0, src));
    idle(2);
    wr(1, dv(ip, fp));
    wr(0, ctl(mode, flip, 0, 0, src));
    wr(0, ctl(mode, flip, 0, 1, src));
  endtask

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    #1 rst_ni = 1'b1;
    // reset state (R2)
    rd(0, 32'h0, "R2 reset ctrl");
    rd(1, 32'h0, "R2 reset div");
    chk(32'(busy_o), 0, "R3 reset busy");
    chk(32'(clk_o), 0, "R4 reset clk_o");
    cmp_en = 1;

    // R1: bad key ignored
    cur_req = "R1";
    wr(1, dv(3, 12'h800, 8'h12));
    rd(1, 32'h0, "R1 bad key div");
    wr(0, ctl(0, 0, 0, 1, 2, 8'hA5));
    idle(3);
    chk(32'(busy_o), 0, "R1 bad key enable");
    rd(0, 32'h0, "R1 bad key ctrl");

    // R2 readback with key byte zero
    wr(1, dv(3, 12'h800));
    rd(1, 32'h0000_3800, "R2 div readback");

    // R3 start timing, R4 mode 0 with fraction ignored
    cur_req = "R4";
    tick_mode = 2;
    wr(0, ctl(0, 0, 0, 1, 2));
    chk(32'(busy_o), 0, "R3 busy not yet");
    @(negedge clk_i); #3;
    chk(32'(busy_o), 1, "R3 busy rise");
    chk(32'(clk_o), 1, "R3 first high");
    idle(150);
    rd(0, 32'h0000_0092, "R2 ctrl with busy");

    // R7 disable
    cur_req = "R7";
    wr(0, ctl(0, 0, 0, 0, 2));
    idle(30);
    chk(32'(busy_o), 0, "R7 stopped");

    // R6 kill mid-run
    cur_req = "R6";
    tick_mode = 1;
    wr(1, dv(5, 0));
    wr(0, ctl(0, 0, 0, 1, 1));
    idle(7);
    wr(0, ctl(0, 0, 1, 1, 1));
    idle(20);
    chk(32'(busy_o), 0, "R6 kill holds idle");

    // R8 shaping mode
    cur_req = "R8";
    reprogram(2, 12'h555, 1, 0, 3);
    idle(200);
    tick_mode = 2;
    idle(200);

    // R4 N=1, N=0, N=3 with fraction under mode 0
    cur_req = "R4";
    tick_mode = 1;
    reprogram(1, 0, 0, 0, 0);
    idle(20);
    reprogram(0, 12'hFFF, 0, 0, 0);
    idle(20);
    reprogram(3, 12'h800, 0, 0, 4);
    idle(60);

    // R5 ground source and top real lane
    cur_req = "R5";
    reprogram(2, 0, 0, 0, 9);
    idle(50);
    chk(32'(clk_o), 1, "R5 ground no edges");
    reprogram(2, 0, 0, 0, 7);
    tick_mode = 2;
    idle(60);

    // R9 flip idle and running
    cur_req = "R9";
    wr(0, ctl(0, 0, 1, 0, 7));
    idle(2);
    wr(0, ctl(0, 1, 0, 0, 7));
    @(negedge clk_i); #3;
    chk(32'(clk_o), 1, "R9 idle flip");
    wr(0, ctl(0, 1, 0, 1, 7));
    idle(40);
    wr(0, ctl(0, 0, 0, 1, 7));
    idle(40);

    // R10 divisor write while running
    cur_req = "R10";
    tick_mode = 1;
    reprogram(5, 0, 0, 0, 6);
    idle(13);
    wr(1, dv(2, 12'h123));
    wr(0, ctl(1, 0, 0, 1, 6));
    rd(1, 32'h0000_2123, "R10 new div stored");
    idle(60);
    wr(0, ctl(1, 0, 0, 0, 6));
    idle(10);
    cmp_en = 0;
    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule